// File: doc/BRIEF.md
# Booth radix-4 counter-tree multiplier

This block multiplies two signed two's complement operands of `W` bits (16 by default) and returns the full signed product of `2W` bits. The multiplier operand is recoded into radix-4 Booth digits, so there are only `W/2` partial-product rows instead of `W`. The sign handling of those rows is folded into one extra constant row.

The resulting row set is compressed by levels of column counters. Each counter takes up to seven bits of one column and emits their binary count as three bits, which land in that column and the next two columns up. Three-input counters (full adders) handle short leftovers. When two rows remain, a carry-propagate adder produces the product.

The result is registered once. A caller raises `in_valid` for one cycle with operands present and reads `product` with `out_valid` in the next cycle. A new operand pair may be presented every cycle.

Top module: `booth_ctree_mul`

## Requirements
- R1: In the cycle after `in_valid` is sampled high, `product` equals the two's complement value of `mcand` times `mplier`, both read as signed, over the full `2W` bits.
- R2: `out_valid` is high in exactly those cycles that follow a rising clock edge at which `in_valid` was high, and low otherwise.
- R3: While `in_valid` is low, `product` keeps its last value whatever the operand inputs do.
- R4: A synchronous active-low reset forces `out_valid` and `product` to zero, regardless of `in_valid` or the operands at that edge.
- R5: Each Booth digit is taken from multiplier bits (2i+1, 2i, 2i-1), with bit -1 read as 0. The encodings are: 000 and 111 give 0; 001 and 010 give +1 times the multiplicand; 011 gives +2 times; 100 gives -2 times; 101 and 110 give -1 times. Multiplier patterns that hit every triplet yield correct products.
- R6: The most negative operand times itself (0x8000 by 0x8000) gives 0x40000000.
- R7: The largest positive operand times itself (0x7FFF by 0x7FFF) gives 0x3FFF0001.
- R8: A zero operand gives a zero product. A multiplier of -1 (0xFFFF) gives the sign-extended negation of the multiplicand, so 0x8000 gives 0x00008000.
- R9: Operand pairs presented on consecutive cycles each produce their own product, in order, one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on `mcand`/`mplier` are to be multiplied |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier (Booth-recoded) |
| out_valid | output | 1 | `product` holds a fresh result |
| product | output | 2W | Signed product, registered |

## Verification
Two functions can meet in one cycle: capturing a new operand pair and presenting the previous result. Operands streamed on consecutive cycles provoke this. The bench checks at every falling edge that the visible product belongs to the pair driven one cycle earlier, not to the pair being driven now. A second collision is a reset that coincides with a valid strobe. The bench asserts reset while `in_valid` is high and checks that the registered output clears to zero rather than loading the new product.

// File: rtl/bctm_pkg.sv
// Package bctm_pkg
// Shared types and elaboration-time helpers for the Booth counter-tree
// multiplier. Assumes the operand width is even and at most 32 bits.
package bctm_pkg;

    // One-hot style control decoded from a Booth triplet.
    typedef struct packed {
        logic neg;   // subtract the selected multiple
        logic one;   // select 1 x multiplicand
        logic two;   // select 2 x multiplicand
    } booth_sel_t;

    // Decode triplet {b(2i+1), b(2i), b(2i-1)} into a digit selection.
    function automatic booth_sel_t booth_decode(input logic [2:0] trip);
        booth_sel_t s;
        s = '0;
        case (trip)
            3'b001, 3'b010: s.one = 1'b1;
            3'b011:         s.two = 1'b1;
            3'b100:         begin s.two = 1'b1; s.neg = 1'b1; end
            3'b101, 3'b110: begin s.one = 1'b1; s.neg = 1'b1; end
            default:        s = '0;          // 000 and 111 pick zero
        endcase
        return s;
    endfunction

    // Rows left after one counter level acting on n rows.
    function automatic int rows_after(input int n);
        int full;
        int rem;
        int outn;
        full = n / 7;
        rem  = n % 7;
        if (rem >= 4)      outn = 3 * full + 3;
        else if (rem == 3) outn = 3 * full + 2;
        else               outn = 3 * full + rem;
        return outn;
    endfunction

    // Rows present at the input of level lvl when n0 rows enter the tree.
    function automatic int rows_at(input int n0, input int lvl);
        int n;
        n = n0;
        for (int k = 0; k < lvl; k++) n = rows_after(n);
        return n;
    endfunction

    // Number of counter levels needed to bring n0 rows down to two.
    function automatic int level_count(input int n0);
        int n;
        int c;
        n = n0;
        c = 0;
        while (n > 2) begin
            n = rows_after(n);
            c++;
        end
        return c;
    endfunction

    // Constant row replacing every row's sign extension: minus the sum of
    // 2^(w+2i) over all rows, taken modulo 2^64.
    function automatic logic [63:0] sext_const(input int w);
        logic [63:0] acc;
        acc = '0;
        for (int i = 0; i < w / 2; i++) acc = acc + (64'd1 << (w + 2 * i));
        return -acc;
    endfunction

endpackage

// File: rtl/ncount.sv
// Module ncount
// Column counter: outputs the binary count of its N input bits. Bit j of
// the count carries weight 2^j relative to the input column. With N = 3 it
// is a full adder; with N = 7 it is the widest cell of the tree.
// Assumes 2 <= N <= 7.
module ncount #(
    parameter  int N  = 7,
    localparam int OW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_i,
    output logic [OW-1:0] count_o
);

    // Population count of the input bits.
    always_comb begin
        count_o = '0;
        for (int k = 0; k < N; k++) count_o = count_o + OW'(bits_i[k]);
    end

endmodule

// File: rtl/booth_ppgen.sv
// Module booth_ppgen
// Builds the partial-product rows of a radix-4 Booth multiplier. It makes
// W/2 rows, each W+1 bits wide before shifting, with the sign bit inverted,
// plus one correction row. The correction row holds the negation ones (at
// bit 2i) and the constant that restores all sign extensions.
// Rows are packed into one vector, row r at bits [r*PW +: PW].
// Assumes W even, 4 <= W <= 32, and PW = 2*W.
module booth_ppgen import bctm_pkg::*; #(
    parameter  int W    = 16,
    localparam int PW   = 2 * W,
    localparam int NPP  = W / 2,
    localparam int NROW = NPP + 1
) (
    input  logic [W-1:0]       mcand_i,
    input  logic [W-1:0]       mplier_i,
    output logic [NROW*PW-1:0] rows_o
);

    localparam logic [PW-1:0] SEXT = PW'(sext_const(W));

    logic [NPP-1:0] neg_v;

    for (genvar i = 0; i < NPP; i++) begin : g_row
        logic [2:0]  trip;
        booth_sel_t  sel;
        logic [W:0]  mag;
        logic [W:0]  pp;

        if (i == 0) begin : g_first
            assign trip = {mplier_i[1], mplier_i[0], 1'b0};
        end else begin : g_next
            assign trip = {mplier_i[2*i+1], mplier_i[2*i], mplier_i[2*i-1]};
        end

        // Pick the digit multiple and apply one's complement for negatives.
        always_comb begin
            sel = booth_decode(trip);
            mag = '0;
            if (sel.one)      mag = {mcand_i[W-1], mcand_i};
            else if (sel.two) mag = {mcand_i, 1'b0};
            pp = sel.neg ? ~mag : mag;
        end

        assign neg_v[i] = sel.neg;
        assign rows_o[i*PW +: PW] = PW'({~pp[W], pp[W-1:0]}) << (2 * i);
    end

    // Correction row: sign-extension constant merged with the +1 bits.
    always_comb begin
        rows_o[NPP*PW +: PW] = SEXT;
        for (int i = 0; i < NPP; i++) rows_o[NPP*PW + 2*i] = neg_v[i];
    end

endmodule

// File: rtl/ctree_level.sv
// Module ctree_level
// One reduction level of the counter tree. Input rows are taken in groups
// of seven, and each column of a group feeds a 7-input counter whose three
// count bits form three new rows, shifted by 0, 1 and 2 columns. Three
// leftover rows go through full adders, four to six through narrower
// counters, and one or two pass unchanged. Bits pushed beyond the top
// column are dropped, which is exact modulo 2^PW.
// Rows above NIN on the input are ignored; rows above the output count are
// driven to zero.
module ctree_level import bctm_pkg::*; #(
    parameter int NIN  = 9,
    parameter int PW   = 32,
    parameter int MAXR = 9
) (
    input  logic [MAXR*PW-1:0] rows_i,
    output logic [MAXR*PW-1:0] rows_o
);

    localparam int NFULL     = NIN / 7;
    localparam int NREM      = NIN % 7;
    localparam int NCELL     = NFULL + ((NREM >= 3) ? 1 : 0);
    localparam int NOUT      = rows_after(NIN);
    localparam int BASE_IN   = 7 * NFULL;
    localparam int BASE_OUT  = 3 * NFULL;

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        localparam int GN = (g < NFULL) ? 7 : NREM;
        localparam int GW = $clog2(GN + 1);

        logic [PW-1:0][GW-1:0] cnts;
        logic [GW-1:0][PW-1:0] ysh;
        logic                  unused_ovf;

        for (genvar c = 0; c < PW; c++) begin : g_col
            logic [GN-1:0] taps;
            for (genvar k = 0; k < GN; k++) begin : g_tap
                assign taps[k] = rows_i[(7*g + k)*PW + c];
            end
            ncount #(.N(GN)) u_cnt (
                .bits_i  (taps),
                .count_o (cnts[c])
            );
        end

        // Place count bit j of column c into output row j at column c+j.
        always_comb begin
            ysh        = '0;
            unused_ovf = 1'b0;
            for (int j = 0; j < GW; j++) begin
                for (int c = 0; c < PW; c++) begin
                    if (c + j < PW) ysh[j][(c + j) % PW] = cnts[c][j];
                    else            unused_ovf = unused_ovf ^ cnts[c][j];
                end
            end
        end

        for (genvar j = 0; j < GW; j++) begin : g_out
            assign rows_o[(3*g + j)*PW +: PW] = ysh[j];
        end
    end

    if (NREM > 0 && NREM < 3) begin : g_pass
        assign rows_o[BASE_OUT*PW +: NREM*PW] = rows_i[BASE_IN*PW +: NREM*PW];
    end

    if (NOUT < MAXR) begin : g_pad
        assign rows_o[MAXR*PW-1 : NOUT*PW] = '0;
    end

    if (NIN < MAXR) begin : g_drop
        logic unused_hi;
        assign unused_hi = ^rows_i[MAXR*PW-1 : NIN*PW];
    end

endmodule

// File: rtl/cpa_add.sv
// Module cpa_add
// Final carry-propagate adder merging the two rows left by the tree.
// The carry out of the top bit is discarded (result modulo 2^PW).
module cpa_add #(
    parameter int PW = 32
) (
    input  logic [PW-1:0] a_i,
    input  logic [PW-1:0] b_i,
    output logic [PW-1:0] sum_o
);

    // Plain binary addition of the two remaining rows.
    always_comb sum_o = a_i + b_i;

endmodule

// File: rtl/booth_ctree_mul.sv
// Module booth_ctree_mul
// Signed W x W multiplier. The datapath is Booth radix-4 row generation,
// then counter-tree reduction to two rows, then a carry-propagate adder.
// One output register stage gives a latency of one cycle. The product
// register loads only on in_valid and holds otherwise.
// Assumes W even and 4 <= W <= 32; synchronous active-low reset.
module booth_ctree_mul import bctm_pkg::*; #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           out_valid,
    output logic [2*W-1:0] product
);

    localparam int PW   = 2 * W;
    localparam int NROW = W / 2 + 1;
    localparam int NLVL = level_count(NROW);
    localparam int MAXR = NROW;

    logic [MAXR*PW-1:0] stage_bus [0:NLVL];
    logic [PW-1:0]      sum;
    logic               unused_rows;

    booth_ppgen #(.W(W)) u_ppgen (
        .mcand_i  (mcand),
        .mplier_i (mplier),
        .rows_o   (stage_bus[0])
    );

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        ctree_level #(
            .NIN  (rows_at(NROW, l)),
            .PW   (PW),
            .MAXR (MAXR)
        ) u_level (
            .rows_i (stage_bus[l]),
            .rows_o (stage_bus[l+1])
        );
    end

    cpa_add #(.PW(PW)) u_cpa (
        .a_i   (stage_bus[NLVL][0 +: PW]),
        .b_i   (stage_bus[NLVL][PW +: PW]),
        .sum_o (sum)
    );

    // Rows above the final two are zero by construction.
    assign unused_rows = ^stage_bus[NLVL][MAXR*PW-1 : 2*PW];

    // Output register: capture on a valid strobe, flag follows the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) product <= sum;
        end
    end

endmodule

// File: rtl/booth_ctree_mul_chk.sv
// Module booth_ctree_mul_chk
// Port-level temporal checks for booth_ctree_mul, attached by bind.
// The reference product is a behavioural signed multiply of the inputs.
module booth_ctree_mul_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [W-1:0]   mcand,
    input logic [W-1:0]   mplier,
    input logic           out_valid,
    input logic [2*W-1:0] product
);

    logic signed [2*W-1:0] ref_p;

    // Behavioural reference of the signed product.
    assign ref_p = (2*W)'($signed(mcand)) * (2*W)'($signed(mplier));

    // R1
    product_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (product == $past(ref_p)));

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));

    // R4
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0));

endmodule

bind booth_ctree_mul booth_ctree_mul_chk #(.W(W)) u_chk (.*);

// File: tb/booth_ctree_mul_bench.sv
`timescale 1ns/1ps
// Directed bench for booth_ctree_mul: one task per scenario, each checking
// its own results at the falling edge after the capturing rising edge.
module booth_ctree_mul_bench;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [W-1:0]  mcand;
    logic [W-1:0]  mplier;
    logic          out_valid;
    logic [31:0]   product;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    booth_ctree_mul #(.W(W)) u_booth_ctree_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mcand     (mcand),
        .mplier    (mplier),
        .out_valid (out_valid),
        .product   (product)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] sa;
        logic signed [31:0] sb;
        sa = 32'($signed(a));
        sb = 32'($signed(b));
        return 32'(sa * sb);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One multiply, result checked one cycle later (R1, R2).
    task automatic run_one(input string tag, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        mcand = a; mplier = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, product, ref_mul(a, b));
        check({tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
    endtask

    // R4: reset state with in_valid high during reset.
    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; mcand = 16'h1234; mplier = 16'h0567;
        repeat (3) @(negedge clk);
        check("R4 reset product", product, 32'd0);
        check("R4 reset valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    endtask

    // R6, R7, R8: arithmetic corners.
    task automatic t_corners;
        run_one("R6 min*min", 16'h8000, 16'h8000);
        check("R6 value", product, 32'h4000_0000);
        run_one("R7 max*max", 16'h7FFF, 16'h7FFF);
        check("R7 value", product, 32'h3FFF_0001);
        run_one("R8 zero mplier", 16'h9ABC, 16'h0000);
        check("R8 zero value", product, 32'd0);
        run_one("R8 zero mcand", 16'h0000, 16'h8001);
        run_one("R8 neg one", 16'h1234, 16'hFFFF);
        check("R8 neg value", product, 32'hFFFF_EDCC);
        run_one("R8 neg one min", 16'h8000, 16'hFFFF);
        check("R8 neg min value", product, 32'h0000_8000);
        run_one("R8 neg one swap", 16'hFFFF, 16'h7FFF);
    endtask

    // R5: multiplier patterns covering every Booth triplet.
    task automatic t_booth;
        logic [15:0] mp [12] = '{16'h0001, 16'h0002, 16'h0003, 16'h0006,
                                 16'h0005, 16'h5555, 16'hAAAA, 16'hCCCC,
                                 16'h3333, 16'h8000, 16'h7FFF, 16'hE38E};
        logic [15:0] mc [4]  = '{16'h1234, 16'hBCDF, 16'h7FFF, 16'h8000};
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 4; j++) begin
                run_one("R5 booth digits", mc[j], mp[i]);
            end
        end
    endtask

    // R1: random operands.
    task automatic t_random;
        for (int k = 0; k < 300; k++) begin
            run_one("R1 random", 16'($urandom), 16'($urandom));
        end
    endtask

    // R9: back-to-back stream, one pair per cycle.
    task automatic t_stream;
        logic [31:0] exp_q;
        bit have;
        have = 0;
        exp_q = '0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (have) begin
                check("R9 stream product", product, exp_q);
                check("R9 stream valid", {31'd0, out_valid}, 32'd1);
            end
            mcand = 16'($urandom); mplier = 16'($urandom); in_valid = 1'b1;
            exp_q = ref_mul(mcand, mplier);
            have = 1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 stream last", product, exp_q);
    endtask

    // R3: operands change while in_valid is low; product must hold.
    task automatic t_hold;
        logic [31:0] held;
        run_one("R3 setup", 16'h4321, 16'hF00D);
        held = product;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R3 hold product", product, held);
            mcand = 16'($urandom); mplier = 16'($urandom);
        end
        @(negedge clk);
        check("R3 hold product end", product, held);
        check("R2 hold valid low", {31'd0, out_valid}, 32'd0);
    endtask

    // R4: reset arriving together with a valid strobe.
    task automatic t_midreset;
        run_one("R4 pre-reset", 16'h7123, 16'h0456);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; mcand = 16'h5A5A; mplier = 16'h3C3C;
        @(negedge clk);
        check("R4 mid reset product", product, 32'd0);
        check("R4 mid reset valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;
    endtask

    initial begin
        t_reset;
        t_corners;
        t_booth;
        t_random;
        t_stream;
        t_hold;
        t_midreset;
        run_one("R1 after reset", 16'hFFFE, 16'h8000);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule